// File: doc/BRIEF.md
# DMA Request Strobes for a Buffered Serial Port

This block produces the two active-low DMA request lines of a serial port that has a 16-entry receive buffer and a 16-entry transmit buffer. It watches how many bytes each buffer holds, the receive trigger threshold, and a one-cycle receive character-timeout pulse. It drives a receive request and a transmit request that a DMA controller uses to move data in or out of the port.

Two signalling rules exist. The single-transfer rule asks for service one byte at a time: the receive request is low whenever a byte is waiting, and the transmit request is low whenever the transmit buffer is empty. The burst rule uses hysteresis. The receive request starts at the trigger threshold or on a timeout and stays on until the receive buffer is drained. The transmit request starts when the transmit buffer is empty and stays on until that buffer is full. The burst rule applies only when the buffers are enabled and the DMA-mode bit is set. Every other setting of the two control bits selects the single-transfer rule.

Each request line is driven by a two-state machine. The states are `REQ_IDLE` (line high) and `REQ_ACTIVE` (line low). The transitions are named *raise* (IDLE to ACTIVE), *drop* (ACTIVE to IDLE) and *keep* (no state change). The state register is the output register. A small mode stage flags the first cycle in which the decoded rule differs from the rule of the previous cycle.

Top module: `dmareq_top`

## Requirements
- R1: While `rst_n` is low, and on the first edge after its release before any raise, both `rx_req_n` and `tx_req_n` are 1 (inactive).
- R2: The burst rule applies exactly when `buf_en`=1 and `dma_burst`=1. The other three combinations select the single-transfer rule.
- R3: Under the single-transfer rule, on each clock edge `rx_req_n` becomes 0 if `rx_level`≠0 and 1 if `rx_level`=0. `rx_tmo` has no effect under this rule.
- R4: Under the single-transfer rule, on each clock edge `tx_req_n` becomes 0 if `tx_level`=0 and 1 otherwise.
- R5: Under the burst rule, the receive machine raises (`rx_req_n` becomes 0 at the next edge) when `rx_level`≠0 and either `rx_level` ≥ the threshold or `rx_tmo`=1. The threshold encoding of `rx_thr_sel` is 00→1, 01→4, 10→8, 11→14 bytes.
- R6: Under the burst rule, the receive machine keeps `rx_req_n` low while `rx_level`≠0, even below the threshold. It drops on the edge where `rx_level`=0, and an empty buffer takes priority over `rx_tmo`.
- R7: Under the burst rule, the transmit machine raises when `tx_level`=0 and keeps `tx_req_n` low through partial fills. It drops only when `tx_level`=16, then stays high through partial levels until the buffer is empty again.
- R8: On the first edge at which the decoded rule differs from the previous cycle's rule, the outputs are evaluated under the new rule with any held request discarded. A newly selected burst rule leaves `rx_req_n` low only if R5's raise condition holds, and leaves `tx_req_n` low only if `tx_level`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_en | input | 1 | Buffers enabled control bit |
| dma_burst | input | 1 | DMA burst-mode select control bit |
| rx_level | input | 5 | Receive buffer occupancy, 0 to 16 |
| rx_thr_sel | input | 2 | Receive threshold select |
| rx_tmo | input | 1 | Receive character-timeout pulse |
| tx_level | input | 5 | Transmit buffer occupancy, 0 to 16 |
| rx_req_n | output | 1 | Receive DMA request, active low |
| tx_req_n | output | 1 | Transmit DMA request, active low |

## Verification
Every result of this block arrives exactly one clock edge after the inputs that cause it. This holds for a level crossing, a timeout pulse, a threshold change and a control-bit change alike, because the state register is the only register on the path to each request line. The bench drives inputs on the falling edge. It updates its reference state right after the next rising edge from the values it drove, and compares both request lines a quarter period later, before new inputs are applied. Under this scheme a one-cycle `rx_tmo` pulse is seen in the comparison that directly follows it. A rule change is judged at the first edge after the control bits move.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_t;

    // Threshold from a 2-bit select, scaled to the buffer depth
    function automatic int unsigned thr_bytes(input logic [1:0] sel,
                                              input int unsigned depth);
        unique case (sel)
            2'd0: return 1;
            2'd1: return depth / 4;
            2'd2: return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/dmareq_mode.sv
module dmareq_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_en,
    input  logic dma_burst,
    output logic burst,
    output logic rule_chg
);
    logic burst_q;

    assign burst = buf_en & dma_burst;

    always_ff @(posedge clk) begin
        if (!rst_n) burst_q <= 1'b0;
        else        burst_q <= burst;
    end

    assign rule_chg = burst ^ burst_q;

endmodule

// File: rtl/dmareq_rx_fsm.sv
module dmareq_rx_fsm #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst,
    input  logic          rule_chg,
    input  logic [CW-1:0] level,
    input  logic [1:0]    thr_sel,
    input  logic          tmo,
    output logic          req_n
);
    import dmareq_pkg::*;

    req_state_t state, nxt;
    logic [CW-1:0] thr;
    logic          have, fire, past_ok;

    assign thr  = CW'(thr_bytes(thr_sel, DEPTH));
    assign have = (level != '0);
    assign fire = have && ((level >= thr) || tmo);

    always_comb begin
        nxt = state;
        unique case (state)
            REQ_IDLE: begin
                if (!burst) nxt = have ? REQ_ACTIVE : REQ_IDLE;
                else if (fire) nxt = REQ_ACTIVE;
            end
            REQ_ACTIVE: begin
                if (!burst)        nxt = have ? REQ_ACTIVE : REQ_IDLE;
                else if (!have)    nxt = REQ_IDLE;
                else if (fire)     nxt = REQ_ACTIVE;
                else if (rule_chg) nxt = REQ_IDLE;
                else               nxt = REQ_ACTIVE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= REQ_IDLE;
            past_ok <= 1'b0;
        end else begin
            state   <= nxt;
            past_ok <= 1'b1;
        end
    end

    always_comb req_n = (state != REQ_ACTIVE);

    // R3: single-transfer receive request follows occupancy
    a_r3_single_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(burst)) |-> (req_n == ($past(level) == '0)));
    // R6: burst rule releases only on an empty buffer
    a_r6_burst_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(burst) && $past(level) == '0) |-> req_n);
    // R6: burst rule holds the request while data remains
    a_r6_burst_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(burst) && !$past(rule_chg) && !$past(req_n)
         && $past(level) != '0) |-> !req_n);

endmodule

// File: rtl/dmareq_tx_fsm.sv
module dmareq_tx_fsm #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst,
    input  logic          rule_chg,
    input  logic [CW-1:0] level,
    output logic          req_n
);
    import dmareq_pkg::*;

    req_state_t state, nxt;
    logic empty, full, past_ok;

    assign empty = (level == '0);
    assign full  = (level == CW'(DEPTH));

    always_comb begin
        nxt = state;
        unique case (state)
            REQ_IDLE: begin
                if (empty) nxt = REQ_ACTIVE;
            end
            REQ_ACTIVE: begin
                if (!burst)        nxt = empty ? REQ_ACTIVE : REQ_IDLE;
                else if (empty)    nxt = REQ_ACTIVE;
                else if (full)     nxt = REQ_IDLE;
                else if (rule_chg) nxt = REQ_IDLE;
                else               nxt = REQ_ACTIVE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= REQ_IDLE;
            past_ok <= 1'b0;
        end else begin
            state   <= nxt;
            past_ok <= 1'b1;
        end
    end

    always_comb req_n = (state != REQ_ACTIVE);

    // R4: single-transfer transmit request only on empty
    a_r4_single_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(burst)) |-> (req_n == ($past(level) != '0)));
    // R7: a full buffer always releases the transmit request
    a_r7_burst_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(level) == CW'(DEPTH)) |-> req_n);
    // R7: an idle burst request stays idle until the buffer empties
    a_r7_burst_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(req_n) && $past(level) != '0) |-> req_n);

endmodule

// File: rtl/dmareq_top.sv
module dmareq_top #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_en,
    input  logic          dma_burst,
    input  logic [CW-1:0] rx_level,
    input  logic [1:0]    rx_thr_sel,
    input  logic          rx_tmo,
    input  logic [CW-1:0] tx_level,
    output logic          rx_req_n,
    output logic          tx_req_n
);
    logic burst, rule_chg;

    dmareq_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_en   (buf_en),
        .dma_burst(dma_burst),
        .burst    (burst),
        .rule_chg (rule_chg)
    );

    dmareq_rx_fsm #(.DEPTH(DEPTH)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .burst   (burst),
        .rule_chg(rule_chg),
        .level   (rx_level),
        .thr_sel (rx_thr_sel),
        .tmo     (rx_tmo),
        .req_n   (rx_req_n)
    );

    dmareq_tx_fsm #(.DEPTH(DEPTH)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .burst   (burst),
        .rule_chg(rule_chg),
        .level   (tx_level),
        .req_n   (tx_req_n)
    );

    // R1: both lines inactive while reset is held
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (rx_req_n && tx_req_n));

endmodule

// File: tb/dmareq_top_tb_top.sv
module dmareq_top_tb_top;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_en = 1'b0, dma_burst = 1'b0, rx_tmo = 1'b0;
    logic [4:0] rx_level = '0, tx_level = '0;
    logic [1:0] rx_thr_sel = '0;
    logic rx_req_n, tx_req_n;

    int checks = 0, errors = 0;
    bit done = 0;
    bit m_rx = 0, m_tx = 0, m_prev = 0;

    always #10 clk = ~clk;

    dmareq_top dut_i (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .dma_burst(dma_burst),
        .rx_level(rx_level), .rx_thr_sel(rx_thr_sel), .rx_tmo(rx_tmo),
        .tx_level(tx_level), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
    );

    // R5 threshold encoding
    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit rx_next(bit cur, bit b, bit chg, int lvl, int thr, bit t);
        bit fire = (lvl != 0) && (lvl >= thr || t);
        if (!b) return lvl != 0;                 // R3
        if (lvl == 0) return 0;                  // R6
        if (fire) return 1;                      // R5
        return cur && !chg;                      // R6 hold, R8 discard
    endfunction

    function automatic bit tx_next(bit cur, bit b, bit chg, int lvl);
        if (!b) return lvl == 0;                 // R4
        if (lvl == 0) return 1;                  // R7
        if (lvl == DEPTH) return 0;              // R7
        return cur && !chg;                      // R7 hold, R8 discard
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit en, input bit bm, input int rl, input int sel,
                        input bit t, input int tl, input string tag);
        bit b, chg;
        @(negedge clk);
        buf_en = en; dma_burst = bm; rx_level = 5'(rl);
        rx_thr_sel = 2'(sel); rx_tmo = t; tx_level = 5'(tl);
        @(posedge clk);
        b    = en & bm;                          // R2 decode
        chg  = b ^ m_prev;
        m_rx = rx_next(m_rx, b, chg, rl, thr_of(2'(sel)), t);
        m_tx = tx_next(m_tx, b, chg, tl);
        m_prev = b;
        #5;
        check({tag, " rx"}, rx_req_n, !m_rx);
        check({tag, " tx"}, tx_req_n, !m_tx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int rl, tl, sel;
        bit en, bm;
        void'($urandom(32'h5eed));
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 rx reset", rx_req_n, 1'b1);
        check("R1 tx reset", tx_req_n, 1'b1);
        @(negedge clk); rst_n = 1'b1;

        // R3/R4 single-transfer, timeout ignored on empty buffer
        step(0, 1, 0, 0, 1, 3, "R3 tmo ignored");
        step(0, 0, 1, 3, 0, 0, "R3R4 single");
        step(1, 0, 0, 0, 0, 1, "R2 en-only is single");
        // R5 thresholds under burst rule: level one below, then at threshold
        for (int s = 0; s < 4; s++) begin
            step(1, 1, 0, s, 0, 16, "R6 empty");
            step(1, 1, thr_of(2'(s)) - 1, s, 0, 16, "R5 below thr");
            step(1, 1, thr_of(2'(s)), s, 0, 16, "R5 at thr");
            step(1, 1, 1, s, 0, 16, "R6 hold low");
        end
        // R5 timeout raise, R6 empty beats timeout
        step(1, 1, 0, 3, 1, 16, "R6 empty beats tmo");
        step(1, 1, 2, 3, 1, 16, "R5 tmo raise");
        step(1, 1, 2, 3, 0, 16, "R6 hold");
        // R7 transmit hysteresis
        step(1, 1, 0, 0, 0, 0, "R7 empty raise");
        step(1, 1, 0, 0, 0, 9, "R7 partial keep");
        step(1, 1, 0, 0, 0, 16, "R7 full drop");
        step(1, 1, 0, 0, 0, 5, "R7 partial idle");
        // R8 rule switch discards a held request
        step(0, 0, 3, 3, 0, 0, "R8 single prep");
        step(1, 1, 3, 3, 0, 4, "R8 switch to burst");
        step(1, 0, 3, 3, 0, 4, "R8 switch to single");

        // constrained random with occupancy counters
        rl = 0; tl = 0; sel = 0; en = 1; bm = 1;
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 2);
            if (r == 0 && rl < DEPTH) rl++; else if (r == 1 && rl > 0) rl--;
            r = $urandom_range(0, 2);
            if (r == 0 && tl < DEPTH) tl++; else if (r == 1 && tl > 0) tl--;
            if ($urandom_range(0, 63) == 0) begin en = $urandom(); bm = $urandom(); end
            if ($urandom_range(0, 127) == 0) sel = $urandom_range(0, 3);
            step(en, bm, rl, sel, $urandom_range(0, 15) == 0, tl, "R2-rand");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule